// File: doc/BRIEF.md
# Dual-Counter Four-Channel PWM Timer

The block holds two free-running up-counters and four compare channels. Each counter has its own prescaler, so it advances once every 2^n clock cycles. Each channel is tied to one of the two counters and drives one PWM pin. A counter wrap switches the channel's output to its active state. A match between the counter and the channel's compare value switches it back to inactive. Each channel raises a one-cycle match pulse, and each counter raises a one-cycle wrap pulse.

Software programs the block through a write-only register port. A channel's output does not move until its counter has wrapped at least once, and a software clear of the counter starts that wait again. An optional stagger mode spreads the activations of channels on the same counter over successive count ticks, so their edges never fall in the same cycle. Compare values written while the timer runs go to a shadow register and take effect at the next wrap.

Top module: `mcpwm_timer`

## Requirements
- R1: After reset, all counters are stopped and at zero, and every pin, match pulse and wrap pulse is 0.
- R2: A counter advances only when both the global power bit (address 0, bit 0) and its own enable bit (address 1 for counter 0, address 2 for counter 1, bit 0) are 1. It goes from all-ones to zero and keeps counting. On that wrap, its wrap pulse is high for exactly one clock cycle.
- R3: The 3-bit prescale field (bits 3:1 of the counter register) selects a count tick every 2^n clock cycles. The prescaler restarts whenever the counter is stopped or cleared.
- R4: Writing a counter register with bit 4 set clears that counter to zero in that cycle and disarms it. Bit 2 of a channel register (addresses 3 to 6 for channels 1 to 4) selects counter 0 (value 0) or counter 1 (value 1).
- R5: A channel takes part in PWM only when both its output-enable bit (bit 0) and its compare-mode bit (bit 1) are 1. Otherwise its pin sits at the inactive level, its state is cleared and it raises no match pulse.
- R6: A channel's output does not change until its counter's first wrap after reset or after a clear. A clear leaves the output level where it is.
- R7: On a wrap the output becomes active. When the counter steps onto the channel's compare value, the output becomes inactive and the match pulse is high for one cycle. The counter is not cleared by a match. If activation and match fall on the same tick, the match wins.
- R8: Channel bit 3 inverts the pin: 0 makes the active state high, 1 makes it low.
- R9: With the stagger bit set (address 0, bit 1), channel m becomes active m-1 count ticks after the wrap. With the bit clear, all channels activate on the wrap tick. A match that comes before a delayed activation cancels that activation for the period.
- R10: Compare values (addresses 8 to 11 for channels 1 to 4) go to a shadow register. The live compare value is loaded from the shadow on each wrap, and continuously while the counter is unarmed.
- R11: A compare value of zero keeps the output inactive for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CNT_W | Register write data |
| pwm_o | output | N_CH | PWM pins, channel 1 in bit 0 |
| match_irq_o | output | N_CH | One-cycle compare-match pulses |
| ovf_irq_o | output | 2 | One-cycle counter wrap pulses |

## Verification
The bench targets the cycles around a wrap: the very first wrap after power-up and after a mid-period clear, where a design that forgets to disarm would switch its outputs too early. It rewrites a compare value in mid-period, which a design without the shadow would apply to the current period. It also uses zero and very small compare values under stagger mode, where the wrong priority between match and delayed activation would leave a pin active for a whole period. A reference model is compared against every pin and pulse on every cycle. Prescale changes and channels moved between counters expose any tick that goes to the wrong counter.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;
  // channel control register layout, bit 0 upward
  typedef struct packed {
    logic inv;       // bit 3: active level low
    logic csel;      // bit 2: counter select
    logic cmp_mode;  // bit 1: compare mode
    logic out_en;    // bit 0: output enable
  } chan_cfg_t;

  localparam int ADDR_GLOBAL = 0;
  localparam int ADDR_CNT_BASE = 1;
  localparam int ADDR_CMP_BASE = 8;
endpackage

// File: rtl/mcpwm_regs.sv
module mcpwm_regs
  import mcpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_CH   = 4,
  parameter int N_CNT  = 2,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              power_o,
  output logic              stagger_o,
  output logic              cnt_en_o [N_CNT],
  output logic [PS_W-1:0]   ps_sel_o [N_CNT],
  output logic              clr_o    [N_CNT],
  output chan_cfg_t         cfg_o    [N_CH],
  output logic [CNT_W-1:0]  cmp_o    [N_CH]
);
  localparam int CH_BASE = ADDR_CNT_BASE + N_CNT;
  localparam int CLR_BIT = PS_W + 1;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      power_o   <= 1'b0;
      stagger_o <= 1'b0;
    end else if (wr_en && hit(wr_addr, ADDR_GLOBAL)) begin
      power_o   <= wr_data[0];
      stagger_o <= wr_data[1];
    end
  end

  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt_reg
    logic sel_w;
    assign sel_w = wr_en && hit(wr_addr, ADDR_CNT_BASE + k);
    assign clr_o[k] = sel_w && wr_data[CLR_BIT];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_en_o[k] <= 1'b0;
        ps_sel_o[k] <= '0;
      end else if (sel_w) begin
        cnt_en_o[k] <= wr_data[0];
        ps_sel_o[k] <= wr_data[PS_W:1];
      end
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_o[c] <= '0;
        cmp_o[c] <= '0;
      end else if (wr_en) begin
        if (hit(wr_addr, CH_BASE + c)) cfg_o[c] <= chan_cfg_t'(wr_data[3:0]);
        if (hit(wr_addr, ADDR_CMP_BASE + c)) cmp_o[c] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/mcpwm_counter.sv
module mcpwm_counter #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [PS_W-1:0]  ps_sel,
  output logic             tick_o,
  output logic             ovf_o,
  output logic             armed_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             ovf_irq_o
);
  localparam int PC_W = (1 << PS_W) - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // tick when the low `sel` bits of the prescaler are all ones
  function automatic logic ps_hit(input logic [PC_W-1:0] pc, input logic [PS_W-1:0] sel);
    logic [PC_W-1:0] mask;
    mask = (PC_W'(1) << sel) - PC_W'(1);
    return (pc & mask) == mask;
  endfunction

  logic [PC_W-1:0]  pcnt_q;
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run && ps_hit(pcnt_q, ps_sel);
  assign ovf_o  = tick_o && !clr && (cnt_q == CNT_MAX);
  assign nxt_o  = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q    <= '0;
      cnt_q     <= '0;
      armed_o   <= 1'b0;
      ovf_irq_o <= 1'b0;
    end else begin
      pcnt_q <= (clr || !run) ? '0 : pcnt_q + PC_W'(1);
      if (clr) cnt_q <= '0;
      else if (tick_o) cnt_q <= nxt_o;
      if (clr) armed_o <= 1'b0;
      else if (ovf_o) armed_o <= 1'b1;
      ovf_irq_o <= ovf_o;
    end
  end

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq_o |-> (cnt_q == '0));
  a_r2_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q));
  a_r4_clear_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!armed_o && cnt_q == '0));
endmodule

// File: rtl/mcpwm_channel.sv
module mcpwm_channel
  import mcpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_CH  = 4,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chan_cfg_t        cfg,
  input  logic             stagger,
  input  logic [CNT_W-1:0] shadow,
  input  logic             tick,
  input  logic             ovf,
  input  logic             clr,
  input  logic             armed,
  input  logic [CNT_W-1:0] nxt,
  output logic             pin_o,
  output logic             match_irq_o,
  output logic             set_ev_o
);
  localparam int DLY_W = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam logic [DLY_W-1:0] MY_DLY = DLY_W'(IDX);

  function automatic logic [DLY_W-1:0] launch_delay(input logic stag);
    return stag ? MY_DLY : '0;
  endfunction

  logic             en, gate, match_ev, act_q, act_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [CNT_W-1:0] cmp_q, cmp_use;

  assign en       = cfg.out_en && cfg.cmp_mode;
  assign cmp_use  = (ovf || !armed) ? shadow : cmp_q;
  assign gate     = armed || ovf;
  assign match_ev = en && tick && !clr && (nxt == cmp_use);
  assign set_ev_o = act_d && !act_q;
  assign pin_o    = (act_q && en) ^ cfg.inv;

  always_comb begin
    act_d = act_q;
    dly_d = dly_q;
    if (!en) begin
      act_d = 1'b0;
      dly_d = '0;
    end else if (clr) begin
      dly_d = '0;
    end else if (match_ev && gate) begin
      act_d = 1'b0;
      dly_d = '0;
    end else if (ovf) begin
      if (launch_delay(stagger) == '0) act_d = 1'b1;
      else dly_d = launch_delay(stagger);
    end else if (tick && dly_q != '0) begin
      dly_d = dly_q - DLY_W'(1);
      if (dly_q == DLY_W'(1)) act_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q       <= 1'b0;
      dly_q       <= '0;
      cmp_q       <= '0;
      match_irq_o <= 1'b0;
    end else begin
      act_q       <= act_d;
      dly_q       <= dly_d;
      cmp_q       <= cmp_use;
      match_irq_o <= match_ev;
    end
  end

  a_r6_hold_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !armed && !ovf) |=> $stable(act_q));
  a_r7_match_deactivates: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && gate) |=> !act_q);
  a_r5_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!act_q && !match_irq_o));
endmodule

// File: rtl/mcpwm_timer.sv
module mcpwm_timer
  import mcpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_CH   = 4,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [N_CH-1:0]   pwm_o,
  output logic [N_CH-1:0]   match_irq_o,
  output logic [1:0]        ovf_irq_o
);
  localparam int N_CNT = 2;  // fixed by the one-bit counter select

  logic             power, stagger;
  logic             cnt_en [N_CNT];
  logic [PS_W-1:0]  ps_sel [N_CNT];
  logic             clr    [N_CNT];
  chan_cfg_t        cfg    [N_CH];
  logic [CNT_W-1:0] cmp    [N_CH];
  logic             tick   [N_CNT];
  logic             ovf    [N_CNT];
  logic             armed  [N_CNT];
  logic [CNT_W-1:0] nxt    [N_CNT];
  logic [N_CH-1:0]  set_ev;

  mcpwm_regs #(
    .CNT_W(CNT_W), .N_CH(N_CH), .N_CNT(N_CNT), .PS_W(PS_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .power_o(power), .stagger_o(stagger), .cnt_en_o(cnt_en), .ps_sel_o(ps_sel),
    .clr_o(clr), .cfg_o(cfg), .cmp_o(cmp)
  );

  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    mcpwm_counter #(.CNT_W(CNT_W), .PS_W(PS_W)) u_cnt (
      .clk, .rst_n,
      .run(power && cnt_en[k]), .clr(clr[k]), .ps_sel(ps_sel[k]),
      .tick_o(tick[k]), .ovf_o(ovf[k]), .armed_o(armed[k]), .nxt_o(nxt[k]),
      .ovf_irq_o(ovf_irq_o[k])
    );
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic s;
    assign s = cfg[c].csel;
    mcpwm_channel #(.CNT_W(CNT_W), .N_CH(N_CH), .IDX(c)) u_ch (
      .clk, .rst_n, .cfg(cfg[c]), .stagger, .shadow(cmp[c]),
      .tick(tick[s]), .ovf(ovf[s]), .clr(clr[s]), .armed(armed[s]), .nxt(nxt[s]),
      .pin_o(pwm_o[c]), .match_irq_o(match_irq_o[c]), .set_ev_o(set_ev[c])
    );
  end

  for (genvar k = 0; k < N_CNT; k++) begin : g_stag_chk
    logic [N_CH-1:0] on_k;
    for (genvar c = 0; c < N_CH; c++) begin : g_on
      assign on_k[c] = (cfg[c].csel == k[0]);
    end
    a_r9_stagger_apart: assert property (@(posedge clk) disable iff (!rst_n)
      stagger |-> $onehot0(set_ev & on_k));
  end
endmodule

// File: tb/mcpwm_timer_tb.sv
module mcpwm_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [3:0] pwm_o, match_irq_o;
  logic [1:0] ovf_irq_o;

  mcpwm_timer #(.CNT_W(W)) u_dut (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .pwm_o, .match_irq_o, .ovf_irq_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;
  bit done = 0;

  // behavioural reference state
  int  m_pc[2], m_cnt[2], m_sel[2];
  bit  m_arm[2], m_ovq[2], m_en[2], m_pow, m_stag;
  bit  m_oe[4], m_cm[4], m_cs[4], m_inv[4], m_act[4], m_mq[4];
  int  m_sh[4], m_ca[4], m_dly[4];

  always @(posedge clk) begin
    bit tk[2], cl[2], ov[2];
    int nx[2];
    if (!rst_n) begin
      m_pow = 0; m_stag = 0;
      for (int k = 0; k < 2; k++) begin
        m_pc[k] = 0; m_cnt[k] = 0; m_sel[k] = 0; m_arm[k] = 0; m_ovq[k] = 0; m_en[k] = 0;
      end
      for (int c = 0; c < 4; c++) begin
        m_oe[c] = 0; m_cm[c] = 0; m_cs[c] = 0; m_inv[c] = 0; m_act[c] = 0;
        m_mq[c] = 0; m_sh[c] = 0; m_ca[c] = 0; m_dly[c] = 0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        int period;
        period = 1 << m_sel[k];
        tk[k] = m_pow && m_en[k] && ((m_pc[k] % period) == period - 1);
        cl[k] = wr_en && wr_addr == 4'(1 + k) && wr_data[4];
        ov[k] = tk[k] && !cl[k] && m_cnt[k] == MAXV;
        nx[k] = (m_cnt[k] + 1) % (MAXV + 1);
      end
      for (int c = 0; c < 4; c++) begin
        int s, use_v;
        bit en, mt;
        s = m_cs[c];
        en = m_oe[c] && m_cm[c];
        use_v = (ov[s] || !m_arm[s]) ? m_sh[c] : m_ca[c];
        mt = en && tk[s] && !cl[s] && nx[s] == use_v;
        m_ca[c] = use_v;
        m_mq[c] = mt;
        if (!en) begin m_act[c] = 0; m_dly[c] = 0; end
        else if (cl[s]) m_dly[c] = 0;
        else if (mt && (m_arm[s] || ov[s])) begin m_act[c] = 0; m_dly[c] = 0; end
        else if (ov[s]) begin
          if (m_stag && c > 0) m_dly[c] = c; else m_act[c] = 1;
        end else if (tk[s] && m_dly[c] > 0) begin
          m_dly[c]--;
          if (m_dly[c] == 0) m_act[c] = 1;
        end
      end
      for (int k = 0; k < 2; k++) begin
        m_pc[k] = (cl[k] || !(m_pow && m_en[k])) ? 0 : (m_pc[k] + 1) % 128;
        if (cl[k]) begin m_cnt[k] = 0; m_arm[k] = 0; end
        else begin
          if (tk[k]) m_cnt[k] = nx[k];
          if (ov[k]) m_arm[k] = 1;
        end
        m_ovq[k] = ov[k];
      end
      if (wr_en) begin
        if (wr_addr == 0) begin m_pow = wr_data[0]; m_stag = wr_data[1]; end
        for (int k = 0; k < 2; k++)
          if (wr_addr == 4'(1 + k)) begin m_en[k] = wr_data[0]; m_sel[k] = int'(wr_data[3:1]); end
        for (int c = 0; c < 4; c++) begin
          if (wr_addr == 4'(3 + c)) begin
            m_oe[c] = wr_data[0]; m_cm[c] = wr_data[1]; m_cs[c] = wr_data[2]; m_inv[c] = wr_data[3];
          end
          if (wr_addr == 4'(8 + c)) m_sh[c] = int'(wr_data);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  int ovf_seen[2];
  int ch4_high;
  bit counting;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < 4; c++) begin
        bit exp_pin;
        exp_pin = (m_act[c] && m_oe[c] && m_cm[c]) ^ m_inv[c];
        check(pwm_o[c] == exp_pin, $sformatf("R5 R6 R7 R8 R9 R10 R11 pwm ch%0d", c + 1),
              int'(pwm_o[c]), int'(exp_pin));
        check(match_irq_o[c] == m_mq[c], $sformatf("R4 R7 match ch%0d", c + 1),
              int'(match_irq_o[c]), int'(m_mq[c]));
      end
      for (int k = 0; k < 2; k++) begin
        check(ovf_irq_o[k] == m_ovq[k], $sformatf("R2 R3 wrap cnt%0d", k),
              int'(ovf_irq_o[k]), int'(m_ovq[k]));
        if (counting && ovf_irq_o[k]) ovf_seen[k]++;
      end
      if (counting && pwm_o[3]) ch4_high++;
    end
  end

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = W'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check(pwm_o == 0 && match_irq_o == 0 && ovf_irq_o == 0, "R1 reset outputs",
          int'({pwm_o, match_irq_o, ovf_irq_o}), 0);
    @(posedge clk); #1;
    // channel setup: ch1 cmp 64, ch2 cmp 128 inverted, ch3 on counter 1 cmp 32, ch4 cmp 0 (R11)
    wr(8, 64); wr(9, 128); wr(10, 32); wr(11, 0);
    wr(3, 'h3); wr(4, 'hB); wr(5, 'h7); wr(6, 'h3);
    wr(0, 'h1);          // power on
    wr(2, 'h3);          // counter 1, prescale 2 (R3)
    ovf_seen[0] = 0; ovf_seen[1] = 0; ch4_high = 0; counting = 1;
    wr(1, 'h1);          // counter 0, prescale 1
    idle(699);
    counting = 0;
    @(negedge clk);
    check(ovf_seen[0] == 2, "R2 wraps of counter 0", ovf_seen[0], 2);
    check(ovf_seen[1] == 1, "R3 wraps of counter 1 at half rate", ovf_seen[1], 1);
    check(ch4_high == 0, "R11 zero compare never active", ch4_high, 0);
    @(posedge clk); #1;
    // R10: rewrite compare mid-period
    wr(8, 200); idle(600);
    // R4 R6: clear counter 0 mid-period, output holds until next wrap
    wr(1, 'h11); idle(400);
    // R9: stagger, ch3 moved to counter 0, ch4 compare below its delay
    wr(0, 'h3); wr(5, 'h3); wr(11, 2); idle(800);
    wr(11, 3); wr(1, 'h5); idle(2500);
    // R5: ch2 output enable off, compare mode alone
    wr(4, 'hA); idle(300);
    // R2: power off then on
    wr(0, 'h2); idle(100);
    @(negedge clk);
    check(ovf_irq_o == 0, "R2 no wrap while stopped", int'(ovf_irq_o), 0);
    @(posedge clk); #1;
    wr(0, 'h1); idle(1500);
    finish_run();
  end
endmodule